// File: doc/BRIEF.md
# Twisted-Pair Link Keep-Alive and Integrity Monitor

This block keeps a twisted-pair 10 Mb/s link alive while the port is quiet and decides whether the far end is still there. While nothing is being transmitted it asks the transmitter for a short idle pulse at a fixed interval. Any transmission restarts that interval and cuts off a pulse already in progress.

On the receive side it watches two things: a strobe from the pulse qualifier, which marks one valid idle pulse from the remote end, and a receive-activity level, which marks real data. If neither shows up for a loss window, the link is declared down. The link-ok output then drops and turns off the port's transmit, receive and collision paths. A run of qualified remote pulses, or any received data, brings the link back. A test bit overrides the verdict and keeps the port enabled. The same verdict drives a good-link LED.

A 20 MHz clock is assumed, which makes the pulse two cycles (100 ns) wide. The 16 ms interval and the roughly 100 ms loss window are parameters, so a simulation can use small values.

Top module: `lnk_keeper`

## Requirements
- R1: Each idle pulse on `lp_req` stays high for exactly PULSE_CYC consecutive cycles (default 2, i.e. 100 ns at 20 MHz), unless `tx_active` cuts it short.
- R2: While `tx_active` is low, `lp_req` rises after every IDLE_CYC-th rising edge counted from reset release or from the last cycle with `tx_active` high. Pulses therefore start IDLE_CYC cycles apart.
- R3: A cycle with `tx_active` high forces `lp_req` low in the following cycle and restarts the idle interval.
- R4: When LOSS_CYC consecutive cycles pass with both `rx_lp_strobe` and `rx_active` low, the link is declared down: `link_ok` and `good_led` go low in the next cycle, unless `lnk_test_off` is set.
- R5: While the link is down, GOOD_PULSES strobes on `rx_lp_strobe` bring it back, with `link_ok` high in the cycle after the last strobe. The strobes must arrive without a loss window expiring between them; an expiry clears the partial count.
- R6: A cycle with `rx_active` high brings the link up in the next cycle, whatever the pulse count.
- R7: After reset, `lp_req`, `link_ok` and `good_led` are low unless `lnk_test_off` is high.
- R8: While `lnk_test_off` is high, `link_ok` and `good_led` are high. The monitor keeps tracking, so the true link state shows at the outputs as soon as the bit is cleared.
- R9: `good_led` always equals `link_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (20 MHz assumed) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Transmit data in progress |
| rx_lp_strobe | input | 1 | One-cycle mark of a qualified remote idle pulse |
| rx_active | input | 1 | Receive data present |
| lnk_test_off | input | 1 | Override: keeps the link reported good |
| lp_req | output | 1 | Idle pulse request to the transmitter |
| good_led | output | 1 | Good-link LED drive, high = on |
| link_ok | output | 1 | Enables transmit, receive and collision detection |

## Verification
A wrong idle-timer count shows on `lp_req` as a pulse that starts early or late, or that runs too long. The bench sees it within one idle interval of reset or of the last transmission. A wrong loss counter or restore counter shows as `link_ok` falling or rising one or more cycles away from the model. This appears within one loss window, or at the last strobe of a restore run. A fault in the override path appears in the first cycle the test bit changes. The bench compares every output with its model on every cycle, so any of these faults is caught in the cycle where it first reaches a port.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
   typedef enum logic {
      LNK_DOWN = 1'b0,
      LNK_UP   = 1'b1
   } lnk_state_e;
endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
   parameter int PULSE_CYC = 2,
   parameter int IDLE_CYC  = 320000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active,
   output logic lp_req
);
   localparam int IDLE_W  = $clog2(IDLE_CYC);
   localparam int PULSE_W = $clog2(PULSE_CYC + 1);
   localparam logic [IDLE_W-1:0]  IDLE_LAST = IDLE_W'(IDLE_CYC - 1);
   localparam logic [PULSE_W-1:0] PULSE_LEN = PULSE_W'(PULSE_CYC);

   if (PULSE_CYC < 2) begin : g_bad_pulse
      $error("lnk_pulse_gen: PULSE_CYC must be at least 2");
   end
   if (IDLE_CYC <= PULSE_CYC + 1) begin : g_bad_idle
      $error("lnk_pulse_gen: IDLE_CYC must exceed PULSE_CYC + 1");
   end

   logic [IDLE_W-1:0]  idle_cnt;
   logic [PULSE_W-1:0] pulse_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_cnt   <= '0;
         pulse_left <= '0;
      end else if (tx_active) begin
         idle_cnt   <= '0;
         pulse_left <= '0;
      end else if (idle_cnt == IDLE_LAST) begin
         idle_cnt   <= '0;
         pulse_left <= PULSE_LEN;
      end else begin
         idle_cnt <= idle_cnt + 1'b1;
         if (pulse_left != '0) pulse_left <= pulse_left - 1'b1;
      end
   end

   assign lp_req = (pulse_left != '0);

   // R3
   tx_quiets_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> !lp_req);

   // R1
   pulse_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lp_req) |=> (lp_req || $past(tx_active)));
endmodule

// File: rtl/lnk_monitor.sv
module lnk_monitor
   import lnk_pkg::*;
#(
   parameter int LOSS_CYC    = 2000000,
   parameter int GOOD_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_lp_strobe,
   input  logic rx_active,
   output logic link_up
);
   localparam int LOSS_W = $clog2(LOSS_CYC);
   localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_CYC - 1);

   if (LOSS_CYC < 4) begin : g_bad_loss
      $error("lnk_monitor: LOSS_CYC must be at least 4");
   end
   if (GOOD_PULSES < 1) begin : g_bad_good
      $error("lnk_monitor: GOOD_PULSES must be at least 1");
   end

   lnk_state_e        state;
   logic [LOSS_W-1:0] quiet_cnt;
   logic              loss_hit;
   logic              run_done;

   assign loss_hit = (quiet_cnt == LOSS_LAST);

   if (GOOD_PULSES == 1) begin : g_single
      assign run_done = 1'b1;
   end else begin : g_counted
      localparam int GOOD_W = $clog2(GOOD_PULSES);
      localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_PULSES - 1);
      logic [GOOD_W-1:0] good_cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            good_cnt <= '0;
         end else if (rx_active || state == LNK_UP) begin
            good_cnt <= '0;
         end else if (rx_lp_strobe) begin
            good_cnt <= (good_cnt == GOOD_LAST) ? '0 : good_cnt + 1'b1;
         end else if (loss_hit) begin
            good_cnt <= '0;
         end
      end

      assign run_done = (good_cnt == GOOD_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= LNK_DOWN;
         quiet_cnt <= '0;
      end else if (rx_active) begin
         state     <= LNK_UP;
         quiet_cnt <= '0;
      end else if (rx_lp_strobe) begin
         quiet_cnt <= '0;
         if (state == LNK_DOWN && run_done) state <= LNK_UP;
      end else if (loss_hit) begin
         state     <= LNK_DOWN;
         quiet_cnt <= '0;
      end else begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   assign link_up = (state == LNK_UP);

   // R6
   rx_data_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_active |=> link_up);

   // R4
   drop_only_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_up) |-> $past(!rx_active && !rx_lp_strobe));

   // R5
   rise_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(rx_active || rx_lp_strobe));
endmodule

// File: rtl/lnk_keeper.sv
module lnk_keeper #(
   parameter int PULSE_CYC   = 2,
   parameter int IDLE_CYC    = 320000,
   parameter int LOSS_CYC    = 2000000,
   parameter int GOOD_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active,
   input  logic rx_lp_strobe,
   input  logic rx_active,
   input  logic lnk_test_off,
   output logic lp_req,
   output logic good_led,
   output logic link_ok
);
   logic link_up;

   lnk_pulse_gen #(
      .PULSE_CYC (PULSE_CYC),
      .IDLE_CYC  (IDLE_CYC)
   ) pgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_active (tx_active),
      .lp_req    (lp_req)
   );

   lnk_monitor #(
      .LOSS_CYC    (LOSS_CYC),
      .GOOD_PULSES (GOOD_PULSES)
   ) mon_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_lp_strobe (rx_lp_strobe),
      .rx_active    (rx_active),
      .link_up      (link_up)
   );

   assign link_ok  = link_up | lnk_test_off;
   assign good_led = link_ok;

   // R8
   override_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_test_off |-> (link_ok && good_led));

   // R9
   led_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      good_led == link_ok);
endmodule

// File: tb/lnk_keeper_tb_top.sv
module lnk_keeper_tb_top;
   localparam int P_PULSE = 2;
   localparam int P_IDLE  = 40;
   localparam int P_LOSS  = 100;
   localparam int P_GOOD  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_active = 1'b0;
   logic rx_lp_strobe = 1'b0;
   logic rx_active = 1'b0;
   logic lnk_test_off = 1'b0;
   logic lp_req, good_led, link_ok;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string tag_lp = "R2";
   string tag_lk = "R7";

   always #10 clk = ~clk;

   lnk_keeper #(
      .PULSE_CYC   (P_PULSE),
      .IDLE_CYC    (P_IDLE),
      .LOSS_CYC    (P_LOSS),
      .GOOD_PULSES (P_GOOD)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_active    (tx_active),
      .rx_lp_strobe (rx_lp_strobe),
      .rx_active    (rx_active),
      .lnk_test_off (lnk_test_off),
      .lp_req       (lp_req),
      .good_led     (good_led),
      .link_ok      (link_ok)
   );

   // behavioural reference: elapsed-time counters updated at each edge
   int  since_tx = 0;
   int  pulse_left = 0;
   int  quiet = 0;
   int  goods = 0;
   bit  up = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         since_tx = 0; pulse_left = 0; quiet = 0; goods = 0; up = 1'b0;
      end else begin
         if (tx_active) begin
            since_tx = 0; pulse_left = 0;
         end else begin
            since_tx++;
            if (pulse_left > 0) pulse_left--;
            if (since_tx % P_IDLE == 0) pulse_left = P_PULSE;
         end
         if (rx_active) begin
            up = 1'b1; quiet = 0; goods = 0;
         end else if (rx_lp_strobe) begin
            quiet = 0;
            if (!up) begin
               goods++;
               if (goods >= P_GOOD) begin up = 1'b1; goods = 0; end
            end
         end else begin
            quiet++;
            if (quiet >= P_LOSS) begin up = 1'b0; quiet = 0; goods = 0; end
         end
      end
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(tag_lp, "lp_req", lp_req, pulse_left > 0);
         check(tag_lk, "link_ok", link_ok, up | lnk_test_off);
         check("R9", "good_led", good_led, up | lnk_test_off);
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe_once();
      rx_lp_strobe = 1'b1;
      @(negedge clk);
      rx_lp_strobe = 1'b0;
   endtask

   initial begin
      wait_cyc(3);
      check("R7", "lp_req in reset", lp_req, 1'b0);
      check("R7", "link_ok in reset", link_ok, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", "link_ok after reset", link_ok, 1'b0);
      check("R7", "good_led after reset", good_led, 1'b0);

      tag_lp = "R1"; tag_lk = "R4";
      wait_cyc(P_IDLE * 3);

      tag_lp = "R3";
      wait_cyc(P_IDLE - 1 - 3);
      tx_active = 1'b1; wait_cyc(5); tx_active = 1'b0;
      wait_cyc(P_IDLE - 1); tx_active = 1'b1; @(negedge clk); tx_active = 1'b0;
      wait_cyc(P_IDLE + 5);
      tag_lp = "R2";

      tag_lk = "R5";
      for (int k = 0; k < P_GOOD; k++) begin strobe_once(); wait_cyc(10); end
      check("R5", "link_ok after pulse run", link_ok, 1'b1);

      tag_lk = "R4";
      wait_cyc(P_LOSS + 5);
      check("R4", "link_ok after silence", link_ok, 1'b0);

      tag_lk = "R5";
      for (int k = 0; k < P_GOOD - 1; k++) begin strobe_once(); wait_cyc(20); end
      wait_cyc(P_LOSS);
      check("R5", "partial run cleared", link_ok, 1'b0);
      strobe_once();
      check("R5", "one strobe after expiry", link_ok, 1'b0);
      for (int k = 0; k < P_GOOD - 1; k++) begin wait_cyc(5); strobe_once(); end
      check("R5", "fresh run", link_ok, 1'b1);

      tag_lk = "R4";
      wait_cyc(P_LOSS + 2);
      tag_lk = "R6";
      rx_active = 1'b1; @(negedge clk); rx_active = 1'b0;
      check("R6", "link_ok after rx data", link_ok, 1'b1);
      rx_active = 1'b1; wait_cyc(P_LOSS + 10); rx_active = 1'b0;

      tag_lk = "R8";
      lnk_test_off = 1'b1;
      wait_cyc(P_LOSS + 10);
      check("R8", "override forces link_ok", link_ok, 1'b1);
      lnk_test_off = 1'b0;
      @(negedge clk);
      check("R8", "true state after override", link_ok, 1'b0);
      lnk_test_off = 1'b1;
      tx_active = 1'b1; wait_cyc(3); tx_active = 1'b0;
      for (int k = 0; k < P_GOOD; k++) begin strobe_once(); wait_cyc(3); end
      lnk_test_off = 1'b0;
      @(negedge clk);
      check("R8", "restored under override", link_ok, 1'b1);
      wait_cyc(20);

      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule